// File: doc/BRIEF.md
# Codec Control Register Interface

This block is the configuration front end of an audio codec. A host writes 16-bit control words to it. Each word has a 7-bit register address in bits 15:9 and a 9-bit data field in bits 8:0, and it is sent most significant bit first. Two serial transports share the same three pins. With `twi_mode` low, `csel` acts as an active-low chip select. With `twi_mode` high, the pins form a 2-wire bus: the host addresses the block, the block acknowledges each byte, and `csel` selects which of two device addresses it answers to.

All pins are sampled in the system clock domain through two-flop synchronizers, and the serial clock is oversampled. The register bank holds ten 9-bit registers at addresses 0 to 9. The left and right line-input pair and the left and right headphone pair can be written together in one word by setting a "link" bit. A write to address 15 restores every register to its default. The whole bank is presented as one flat parallel bus. Headphone mute flags and an active flag are decoded from it for the neighbouring analog logic.

Top module: `ccr_ctrl_port`

## Requirements
- R1: After synchronous reset the registers hold these values: addresses 0 and 1 hold 0x097, addresses 2 and 3 hold 0x079, address 4 holds 0x008, address 7 holds 0x002, and every other address holds 0x000.
- R2: In 3-wire mode (`twi_mode`=0), `ser_dat` is shifted in on each rising `ser_clk` while `csel` is low, most significant bit first. The word is committed when `csel` rises. Word bits 15:9 are the address and bits 8:0 are the data.
- R3: A 3-wire frame that carries other than exactly 16 rising clock edges while `csel` is low is discarded.
- R4: In 2-wire mode, a frame is a start condition (data falls while clock is high), an address byte with R/W in bit 0, and two data bytes (word bits 15:8, then 7:0). The block drives `dat_oe`=1 during the ninth clock of each accepted byte and commits the word only after the second data byte has been acknowledged. A stop is data rising while clock is high.
- R5: The 2-wire device address is 0011010 when `csel` is low and 0011011 when `csel` is high.
- R6: A 2-wire frame whose address does not match, or whose R/W bit is 1, is not acknowledged and changes no register.
- R7: Only the transport selected by `twi_mode` is active. A 2-wire frame in 3-wire mode neither acknowledges nor commits. Toggling `csel` in 2-wire mode commits nothing.
- R8: A write to address 0, 1, 2 or 3 with data bit 8 set stores the same 9-bit value in both that register and its partner (address XOR 1).
- R9: A write to address 15, with any data, restores all registers to their R1 defaults.
- R10: Writes to addresses 10 to 14 and 16 to 127 change no register.
- R11: `hp_mute_l` (or `hp_mute_r`) is 1 exactly when bits 6:0 of register 2 (or register 3) are below 0x30. `codec_active` equals bit 0 of register 9.
- R12: `cfg_regs[9n+8:9n]` carries register n, for n from 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| twi_mode | input | 1 | 1 selects the 2-wire transport, 0 selects the 3-wire transport |
| csel | input | 1 | Chip select (active low) in 3-wire mode; device-address select in 2-wire mode |
| ser_clk | input | 1 | Serial clock |
| ser_dat | input | 1 | Serial data in (the resolved open-drain line in 2-wire mode) |
| dat_oe | output | 1 | Pull the data line low to acknowledge (2-wire mode) |
| cfg_regs | output | 90 | Flat register bank contents |
| hp_mute_l | output | 1 | Left headphone volume is in the mute range |
| hp_mute_r | output | 1 | Right headphone volume is in the mute range |
| codec_active | output | 1 | Active control bit |

## Verification
The bench targets the link bit on both pairs. A design that ignores the link bit would leave the partner register stale, and one that XORs the wrong address bit would corrupt an unrelated register. Short 3-wire frames and unimplemented addresses probe the discard rules: a design without the exact-count rule, or one that truncates the address to four bits, would write a register it must not touch. The 2-wire tests flip the `csel` level, mismatch the address and set the read bit, and check the acknowledge level on every ninth clock. A wrong address decode shows up as a missing or extra acknowledge. Random mixed traffic across both modes, with soft resets interleaved, is compared against a bench model after every frame.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 9;
    localparam int WORD_W     = ADDR_W + DATA_W;
    localparam int NREG       = 10;
    localparam int FLAT_W     = NREG * DATA_W;
    localparam int LINK_PAIRS = 2;
    localparam int BYTE_W     = 8;
    localparam int BCNT_W     = $clog2(BYTE_W + 1);
    localparam int SCNT_W     = 5;
    localparam logic [ADDR_W-1:0] SOFT_RST_ADDR = 7'd15;
    localparam int HP_MUTE_LIMIT = 48;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } ctrl_word_t;

    typedef enum logic [2:0] {
        TW_IDLE, TW_ADDR, TW_ACKA, TW_BYTE1,
        TW_ACK1, TW_BYTE2, TW_ACK2, TW_SKIP
    } twi_state_t;

    function automatic logic [DATA_W-1:0] reg_default(input int idx);
        case (idx)
            0, 1:    return 9'h097;
            2, 3:    return 9'h079;
            4:       return 9'h008;
            7:       return 9'h002;
            default: return '0;
        endcase
    endfunction

    function automatic logic [FLAT_W-1:0] default_flat();
        logic [FLAT_W-1:0] f;
        for (int i = 0; i < NREG; i++) f[i*DATA_W +: DATA_W] = reg_default(i);
        return f;
    endfunction

    function automatic logic addr_hit(input logic [ADDR_W-1:0] a);
        return int'(a) < NREG;
    endfunction

    function automatic logic addr_linked(input logic [ADDR_W-1:0] a);
        return int'(a) < 2 * LINK_PAIRS;
    endfunction

endpackage

// File: rtl/ccr_sync.sv
module ccr_sync #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/ccr_spi_rx.sv
module ccr_spi_rx
    import ccr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       sdi,
    output logic       word_valid,
    output ctrl_word_t word
);
    logic              cs_p, sclk_p;
    logic [WORD_W-1:0] shreg;
    logic [SCNT_W-1:0] cnt;

    wire cs_rise  = cs_n & ~cs_p;
    wire cs_fall  = ~cs_n & cs_p;
    wire clk_rise = sclk & ~sclk_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_p       <= 1'b1;
            sclk_p     <= 1'b1;
            shreg      <= '0;
            cnt        <= '0;
            word_valid <= 1'b0;
            word       <= '0;
        end else begin
            cs_p       <= cs_n;
            sclk_p     <= sclk;
            word_valid <= 1'b0;
            if (!en) begin
                cnt <= '0;
            end else if (cs_fall) begin
                cnt <= '0;
            end else if (cs_rise) begin
                if (cnt == SCNT_W'(WORD_W)) begin
                    word_valid <= 1'b1;
                    word       <= ctrl_word_t'(shreg);
                end
            end else if (!cs_n && clk_rise) begin
                shreg <= {shreg[WORD_W-2:0], sdi};
                if (cnt != '1) cnt <= cnt + 1'b1;
            end
        end
    end

    // R2
    spi_commit_edge_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> ($past(cs_n) && !$past(cs_n, 2)));

endmodule

// File: rtl/ccr_twi_rx.sv
module ccr_twi_rx
    import ccr_pkg::*;
#(
    parameter logic [ADDR_W-2:0] DEV_ADDR_HI = 6'b001101
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       addr_lsb,
    input  logic       scl,
    input  logic       sda,
    output logic       dat_oe,
    output logic       word_valid,
    output ctrl_word_t word
);
    twi_state_t        st;
    logic              scl_p, sda_p;
    logic [BYTE_W-1:0] shreg, byte1;
    logic [BCNT_W-1:0] bcnt;

    wire scl_rise = scl & ~scl_p;
    wire scl_fall = ~scl & scl_p;
    wire start_c  = scl & scl_p & sda_p & ~sda;
    wire stop_c   = scl & scl_p & ~sda_p & sda;
    wire byte_done = (bcnt == BCNT_W'(BYTE_W));
    wire [BYTE_W-1:0] my_wr_addr = {DEV_ADDR_HI, addr_lsb, 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= TW_IDLE;
            scl_p      <= 1'b1;
            sda_p      <= 1'b1;
            shreg      <= '0;
            byte1      <= '0;
            bcnt       <= '0;
            dat_oe     <= 1'b0;
            word_valid <= 1'b0;
            word       <= '0;
        end else begin
            scl_p      <= scl;
            sda_p      <= sda;
            word_valid <= 1'b0;
            if (!en) begin
                st     <= TW_IDLE;
                dat_oe <= 1'b0;
            end else if (start_c) begin
                st     <= TW_ADDR;
                bcnt   <= '0;
                dat_oe <= 1'b0;
            end else if (stop_c) begin
                st     <= TW_IDLE;
                dat_oe <= 1'b0;
            end else if (scl_rise && !byte_done &&
                         (st == TW_ADDR || st == TW_BYTE1 || st == TW_BYTE2)) begin
                shreg <= {shreg[BYTE_W-2:0], sda};
                bcnt  <= bcnt + 1'b1;
            end else if (scl_fall) begin
                case (st)
                    TW_ADDR: if (byte_done) begin
                        if (shreg == my_wr_addr) begin
                            st     <= TW_ACKA;
                            dat_oe <= 1'b1;
                        end else begin
                            st <= TW_SKIP;
                        end
                    end
                    TW_BYTE1: if (byte_done) begin
                        byte1  <= shreg;
                        st     <= TW_ACK1;
                        dat_oe <= 1'b1;
                    end
                    TW_BYTE2: if (byte_done) begin
                        st     <= TW_ACK2;
                        dat_oe <= 1'b1;
                    end
                    TW_ACKA: begin
                        st <= TW_BYTE1; bcnt <= '0; dat_oe <= 1'b0;
                    end
                    TW_ACK1: begin
                        st <= TW_BYTE2; bcnt <= '0; dat_oe <= 1'b0;
                    end
                    TW_ACK2: begin
                        st         <= TW_SKIP;
                        dat_oe     <= 1'b0;
                        word_valid <= 1'b1;
                        word       <= ctrl_word_t'({byte1, shreg});
                    end
                    default: ;
                endcase
            end
        end
    end

    // R4
    twi_ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> !dat_oe && $past(dat_oe));

endmodule

// File: rtl/ccr_regbank.sv
module ccr_regbank
    import ccr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  ctrl_word_t        wr_word,
    output logic [FLAT_W-1:0] flat
);
    logic [DATA_W-1:0] regs_q [NREG];

    wire soft_rst = wr_valid && (wr_word.addr == SOFT_RST_ADDR);
    wire link     = wr_word.data[DATA_W-1] && addr_linked(wr_word.addr);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [ADDR_W-1:0] MY_ADDR   = ADDR_W'(i);
        localparam logic [ADDR_W-1:0] PART_ADDR = ADDR_W'(i ^ 1);
        localparam logic              IN_PAIR   = (i < 2 * LINK_PAIRS);

        always_ff @(posedge clk) begin
            if (rst || soft_rst) begin
                regs_q[i] <= reg_default(i);
            end else if (wr_valid) begin
                if (wr_word.addr == MY_ADDR)
                    regs_q[i] <= wr_word.data;
                else if (IN_PAIR && link && wr_word.addr == PART_ADDR)
                    regs_q[i] <= wr_word.data;
            end
        end

        assign flat[i*DATA_W +: DATA_W] = regs_q[i];
    end

    // R1
    reset_default_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> flat == default_flat());

    // R9
    soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> flat == default_flat());

    // R10
    unimpl_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !addr_hit(wr_word.addr) && !soft_rst) |=> $stable(flat));

    for (genvar p = 0; p < LINK_PAIRS; p++) begin : g_link_chk
        // R8
        link_pair_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_valid && link && wr_word.addr[ADDR_W-1:1] == (ADDR_W-1)'(p))
            |=> regs_q[2*p] == regs_q[2*p+1]);
    end

endmodule

// File: rtl/ccr_ctrl_port.sv
module ccr_ctrl_port
    import ccr_pkg::*;
#(
    parameter logic [ADDR_W-2:0] DEV_ADDR_HI = 6'b001101
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              twi_mode,
    input  logic              csel,
    input  logic              ser_clk,
    input  logic              ser_dat,
    output logic              dat_oe,
    output logic [FLAT_W-1:0] cfg_regs,
    output logic              hp_mute_l,
    output logic              hp_mute_r,
    output logic              codec_active
);
    localparam int          NSYNC    = 4;
    localparam logic [NSYNC-1:0] SYNC_RST = 4'b1110;

    logic [NSYNC-1:0] raw, syn;
    assign raw = {ser_dat, ser_clk, csel, twi_mode};

    for (genvar k = 0; k < NSYNC; k++) begin : g_sync
        ccr_sync #(.RST_VAL(SYNC_RST[k])) u_sync (
            .clk(clk), .rst(rst), .d(raw[k]), .q(syn[k])
        );
    end

    wire mode_s = syn[0];
    wire csel_s = syn[1];
    wire clk_s  = syn[2];
    wire dat_s  = syn[3];

    logic       spi_v, twi_v;
    ctrl_word_t spi_w, twi_w, wr_w;

    ccr_spi_rx u_spi (
        .clk(clk), .rst(rst), .en(!mode_s), .cs_n(csel_s),
        .sclk(clk_s), .sdi(dat_s), .word_valid(spi_v), .word(spi_w)
    );

    ccr_twi_rx #(.DEV_ADDR_HI(DEV_ADDR_HI)) u_twi (
        .clk(clk), .rst(rst), .en(mode_s), .addr_lsb(csel_s),
        .scl(clk_s), .sda(dat_s), .dat_oe(dat_oe),
        .word_valid(twi_v), .word(twi_w)
    );

    assign wr_w = twi_v ? twi_w : spi_w;

    ccr_regbank u_bank (
        .clk(clk), .rst(rst), .wr_valid(spi_v | twi_v),
        .wr_word(wr_w), .flat(cfg_regs)
    );

    assign hp_mute_l    = int'(cfg_regs[2*DATA_W +: 7]) < HP_MUTE_LIMIT;
    assign hp_mute_r    = int'(cfg_regs[3*DATA_W +: 7]) < HP_MUTE_LIMIT;
    assign codec_active = cfg_regs[9*DATA_W];

    // R7
    mode_oe_chk: assert property (@(posedge clk) disable iff (rst)
        dat_oe |-> $past(mode_s));

    // R7
    one_source_chk: assert property (@(posedge clk) disable iff (rst)
        !(spi_v && twi_v));

endmodule

// File: tb/ccr_ctrl_port_bench.sv
module ccr_ctrl_port_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic twi_mode = 1'b0;
    logic csel = 1'b1;
    logic ser_clk = 1'b1;
    logic sda_m = 1'b1;
    logic dat_oe, hp_mute_l, hp_mute_r, codec_active;
    logic [89:0] cfg_regs;
    wire  ser_dat = sda_m & ~dat_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [8:0] exp_r [10];

    always #10 clk = ~clk;

    ccr_ctrl_port u_ccr_ctrl_port (
        .clk(clk), .rst(rst), .twi_mode(twi_mode), .csel(csel),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .dat_oe(dat_oe),
        .cfg_regs(cfg_regs), .hp_mute_l(hp_mute_l), .hp_mute_r(hp_mute_r),
        .codec_active(codec_active)
    );

    function automatic logic [8:0] dflt(input int i);
        if (i < 2) return 9'h097;
        if (i < 4) return 9'h079;
        if (i == 4) return 9'h008;
        if (i == 7) return 9'h002;
        return 9'h000;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 10; i++) exp_r[i] = dflt(i);
    endtask

    task automatic model_write(input logic [15:0] w);
        int a;
        a = int'(w[15:9]);
        if (a == 15) model_reset();
        else if (a < 10) begin
            exp_r[a] = w[8:0];
            if (a < 4 && w[8]) exp_r[a ^ 1] = w[8:0];
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [89:0] act, input logic [89:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [89:0] f;
        for (int i = 0; i < 10; i++) f[i*9 +: 9] = exp_r[i];
        chk(cfg_regs, f, {"R12 bank ", tag});
        chk(90'(hp_mute_l), 90'(int'(exp_r[2][6:0]) < 48), {"R11 mute_l ", tag});
        chk(90'(hp_mute_r), 90'(int'(exp_r[3][6:0]) < 48), {"R11 mute_r ", tag});
        chk(90'(codec_active), 90'(exp_r[9][0]), {"R11 active ", tag});
    endtask

    task automatic spi_xfer(input logic [15:0] w, input int nbits);
        csel = 1'b0;
        wt(4);
        for (int i = 0; i < nbits; i++) begin
            ser_clk = 1'b0;
            wt(2);
            sda_m = w[15 - i];
            wt(2);
            ser_clk = 1'b1;
            wt(4);
        end
        csel = 1'b1;
        wt(4);
        sda_m = 1'b1;
        wt(12);
    endtask

    task automatic twi_bit(input logic b);
        ser_clk = 1'b0;
        wt(3);
        sda_m = b;
        wt(3);
        ser_clk = 1'b1;
        wt(6);
    endtask

    task automatic twi_ack(input logic exp_ack, input string tag);
        ser_clk = 1'b0;
        wt(3);
        sda_m = 1'b1;
        wt(3);
        chk(90'(dat_oe), 90'(exp_ack), tag);
        ser_clk = 1'b1;
        wt(6);
    endtask

    task automatic twi_frame(input logic [6:0] dev, input logic rw,
                             input logic [15:0] w, input logic exp_ack,
                             input string tag);
        logic [7:0] b;
        sda_m = 1'b1; ser_clk = 1'b1;
        wt(6);
        sda_m = 1'b0;
        wt(6);
        b = {dev, rw};
        for (int i = 7; i >= 0; i--) twi_bit(b[i]);
        twi_ack(exp_ack, {"R4/R6 addr ack ", tag});
        if (exp_ack) begin
            for (int i = 15; i >= 8; i--) twi_bit(w[i]);
            twi_ack(1'b1, {"R4 byte1 ack ", tag});
            for (int i = 7; i >= 0; i--) twi_bit(w[i]);
            twi_ack(1'b1, {"R4 byte2 ack ", tag});
        end
        ser_clk = 1'b0;
        wt(3);
        sda_m = 1'b0;
        wt(3);
        ser_clk = 1'b1;
        wt(6);
        sda_m = 1'b1;
        wt(12);
    endtask

    task automatic set_mode(input logic m);
        if (twi_mode != m) begin
            twi_mode = m;
            wt(10);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        model_reset();
        wt(5);
        rst = 1'b0;
        wt(2);
        check_all("R1 reset");

        // R2: plain 3-wire write to the format register
        w = {7'd7, 9'h04A}; spi_xfer(w, 16); model_write(w); check_all("R2 spi reg7");
        // R8: linked line-input write
        w = {7'd0, 9'h11C}; spi_xfer(w, 16); model_write(w); check_all("R8 link 0->1");
        // R8 + R11: linked headphone write into mute range
        w = {7'd3, 9'h120}; spi_xfer(w, 16); model_write(w); check_all("R8 R11 link 3->2");
        w = {7'd2, 9'h07F}; spi_xfer(w, 16); model_write(w); check_all("R11 unlinked 2");
        // R3: short and long frames are dropped
        spi_xfer({7'd5, 9'h1FF}, 15); check_all("R3 short frame");
        spi_xfer({7'd5, 9'h1FF}, 17); check_all("R3 long frame");
        // R10: unimplemented addresses
        w = {7'd12, 9'h1AA}; spi_xfer(w, 16); model_write(w); check_all("R10 addr12");
        w = {7'h50, 9'h155}; spi_xfer(w, 16); model_write(w); check_all("R10 addr80");
        w = {7'd9, 9'h001}; spi_xfer(w, 16); model_write(w); check_all("R11 active set");
        // R9: soft reset
        w = {7'd15, 9'h000}; spi_xfer(w, 16); model_write(w); check_all("R9 soft reset");
        // R7: 2-wire frame while in 3-wire mode
        twi_frame(7'h1A, 1'b0, {7'd6, 9'h0F0}, 1'b0, "R7 twi in spi mode");
        check_all("R7 twi in spi mode");

        set_mode(1'b1);
        csel = 1'b0; wt(6);
        w = {7'd6, 9'h0F0}; twi_frame(7'h1A, 1'b0, w, 1'b1, "R4 low addr");
        model_write(w); check_all("R4 twi write");
        csel = 1'b1; wt(6);
        w = {7'd1, 9'h133}; twi_frame(7'h1B, 1'b0, w, 1'b1, "R5 high addr");
        model_write(w); check_all("R5 R8 twi link");
        twi_frame(7'h1A, 1'b0, {7'd4, 9'h1FF}, 1'b0, "R6 wrong addr");
        check_all("R6 wrong addr");
        twi_frame(7'h1B, 1'b1, {7'd4, 9'h1FF}, 1'b0, "R6 read bit");
        check_all("R6 read bit");
        csel = 1'b1; wt(6);
        spi_xfer({7'd8, 9'h1FF}, 16); check_all("R7 spi in twi mode");

        void'($urandom(32'd4242));
        for (int it = 0; it < 80; it++) begin
            logic [6:0] a;
            int r;
            r = int'($urandom % 20);
            a = (r < 16) ? 7'(r) : 7'($urandom % 128);
            w = {a, 9'($urandom)};
            if (($urandom % 2) == 0) begin
                set_mode(1'b0);
                if (($urandom % 8) == 0) spi_xfer(w, 12);
                else begin spi_xfer(w, 16); model_write(w); end
            end else begin
                logic cs;
                set_mode(1'b1);
                cs = 1'($urandom);
                csel = cs; wt(6);
                r = int'($urandom % 8);
                if (r == 0) twi_frame({6'b001101, ~cs}, 1'b0, w, 1'b0, "R6 rnd");
                else if (r == 1) twi_frame({6'b001101, cs}, 1'b1, w, 1'b0, "R6 rnd");
                else begin
                    twi_frame({6'b001101, cs}, 1'b0, w, 1'b1, "R4 rnd");
                    model_write(w);
                end
            end
            check_all("R2 R4 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule